// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block is a small memory-mapped master for a two-wire serial management bus of the clause-22 kind. Software programs a control register with a clock divisor and a preamble option. It then writes one packed 32-bit frame word to a second register. That write launches the transaction.

The block generates the management clock and shifts the frame word out as given, most significant bit first. An optional run of 32 idle-high bits goes ahead of the frame. On a read frame the block releases the data line for the turnaround and data phases and captures the 16 bits the device returns. When the frame is over it raises a completion flag, which software polls in the control register.

All framing fields are built by software: start, opcode, device and register address, turnaround and data. The block never reinterprets the word. This lets any addressing scheme pass through unchanged, including one where a device-select frame comes before the access frame.

Top module: `mdio_master`

## Requirements
- R1: The control register is at offset 0x128 and holds the divisor in bits 6:0, the preamble enable in bit 7 and the read-only completion flag in bit 8. The frame register is at offset 0x12C. Any other offset reads 0, and both registers read 0 after reset.
- R2: A write to 0x12C starts a transaction when the control register is nonzero and no transaction is running. The 32-bit word goes out verbatim, bit 31 first, so a device-select frame (register field 0x1F in bits 22:18, device number in bits 8:4) leaves the block unchanged.
- R3: The management clock has a period of 2×(divisor+1) system clocks and stays low while idle. The data output changes only as the clock falls and is held while the clock is high.
- R4: With bit 7 set, 32 one-bits are sent before the frame, for 64 clock cycles in total. With bit 7 clear, only the 32 frame bits are sent.
- R5: When bit 29 of the frame word is set (read), the output enable drops from frame bit 16 through frame bit 0. It is high for the preamble and for frame bits 31 to 17, and low while idle.
- R6: A read captures 16 bits from the data input on rising clock edges, first bit received into bit 15. A read of 0x12C returns the captured value in bits 15:0, with bits 31:16 zero.
- R7: The completion flag clears when a transaction starts. It is still clear at the last rising edge of the clock, sets on the falling edge that ends frame bit 0, and holds until the next start.
- R8: A write to 0x12C while a transaction runs is ignored: the bits on the line and their count are those of the first frame.
- R9: With the control register at 0, a write to 0x12C starts nothing: no clock edges appear and the completion flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench aims at the turnaround boundary. A release one bit late would drive against the device's first turnaround bit; a release one bit early would drop the master's own turnaround bit. The bench also times the completion flag against the last clock edges, because a flag raised at the final rising edge lets software read data before the last bit is captured. The remaining cases are a second frame write during a busy transaction, which a careless design would use to reload the shifter mid-frame, and a launch with the controller disabled. It also measures the clock period for several divisors, because an off-by-one in the divider changes the bus rate without breaking the framing.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_BITS = 32;
   localparam int PRE_BITS   = 32;
   localparam int RD_BITS    = 16;
   localparam int RD_BIT_POS = 29;

   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_PRE   = 2'd1,
      SH_FRAME = 2'd2
   } sh_state_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_tick,
   output logic             fall_tick
);
   logic [DIV_W-1:0] cnt_q;
   logic             hit;

   assign hit       = run && (cnt_q == div);
   assign rise_tick = hit && !mdc;
   assign fall_tick = hit && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (hit) begin
         cnt_q <= '0;
         mdc   <= ~mdc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
   import mdio_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [FRAME_BITS-1:0] cmd,
   input  logic                  pre_en,
   input  logic                  rise_tick,
   input  logic                  fall_tick,
   input  logic                  mdio_i,
   output logic                  busy,
   output logic                  mdio_o,
   output logic                  mdio_oe,
   output logic                  done_pulse,
   output logic [RD_BITS-1:0]    cap
);
   localparam int CNT_W = $clog2((PRE_BITS > FRAME_BITS) ? PRE_BITS : FRAME_BITS);
   localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_BITS - 1);
   localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] RD_LIMIT   = CNT_W'(RD_BITS);

   if (RD_BITS >= FRAME_BITS - 2) begin : g_bad_rd
      $error("mdio_shifter: read field does not fit in frame");
   end

   sh_state_t             state_q;
   logic [FRAME_BITS-1:0] sr_q;
   logic                  is_rd_q;
   logic [CNT_W-1:0]      bit_q;
   logic                  last_bit;
   logic                  rd_tail;

   assign last_bit   = (bit_q == '0);
   assign rd_tail    = is_rd_q && (bit_q <= RD_LIMIT);
   assign busy       = (state_q != SH_IDLE);
   assign done_pulse = (state_q == SH_FRAME) && fall_tick && last_bit;
   assign mdio_o     = (state_q == SH_FRAME) ? sr_q[FRAME_BITS-1] : 1'b1;
   assign mdio_oe    = (state_q == SH_PRE) || ((state_q == SH_FRAME) && !rd_tail);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SH_IDLE;
         sr_q    <= '0;
         is_rd_q <= 1'b0;
         bit_q   <= '0;
         cap     <= '0;
      end else begin
         case (state_q)
            SH_IDLE: begin
               if (start) begin
                  sr_q    <= cmd;
                  is_rd_q <= cmd[RD_BIT_POS];
                  if (pre_en) begin
                     state_q <= SH_PRE;
                     bit_q   <= PRE_LAST;
                  end else begin
                     state_q <= SH_FRAME;
                     bit_q   <= FRAME_LAST;
                  end
               end
            end
            SH_PRE: begin
               if (fall_tick) begin
                  if (last_bit) begin
                     state_q <= SH_FRAME;
                     bit_q   <= FRAME_LAST;
                  end else begin
                     bit_q <= bit_q - 1'b1;
                  end
               end
            end
            SH_FRAME: begin
               if (rise_tick && is_rd_q && (bit_q < RD_LIMIT)) begin
                  cap <= {cap[RD_BITS-2:0], mdio_i};
               end
               if (fall_tick) begin
                  sr_q <= sr_q << 1;
                  if (last_bit) begin
                     state_q <= SH_IDLE;
                  end else begin
                     bit_q <= bit_q - 1'b1;
                  end
               end
            end
            default: state_q <= SH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
   import mdio_pkg::*;
#(
   parameter int              ADDR_W       = 12,
   parameter int              DIV_W        = 7,
   parameter bit              HAS_PREAMBLE = 1'b1,
   parameter logic [ADDR_W-1:0] CTRL_OFS   = ADDR_W'(12'h128),
   parameter logic [ADDR_W-1:0] DATA_OFS   = ADDR_W'(12'h12C)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic              busy,
   input  logic              done_pulse,
   input  logic [RD_BITS-1:0] cap,
   output logic [DIV_W-1:0]  div,
   output logic              pre_en,
   output logic              enabled,
   output logic              done,
   output logic              start,
   output logic [31:0]       rdata
);
   localparam int PRE_POS  = 7;
   localparam int DONE_POS = 8;

   logic ctrl_hit;
   logic data_hit;

   assign ctrl_hit = (addr == CTRL_OFS);
   assign data_hit = (addr == DATA_OFS);
   assign enabled  = pre_en || (div != '0);
   assign start    = wr_en && data_hit && enabled && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div <= '0;
      end else if (wr_en && ctrl_hit) begin
         div <= wdata[DIV_W-1:0];
      end
   end

   if (HAS_PREAMBLE) begin : g_pre
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_en <= 1'b0;
         end else if (wr_en && ctrl_hit) begin
            pre_en <= wdata[PRE_POS];
         end
      end
   end else begin : g_no_pre
      assign pre_en = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
      end else if (start) begin
         done <= 1'b0;
      end else if (done_pulse) begin
         done <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      if (ctrl_hit) begin
         rdata[DIV_W-1:0] = div;
         rdata[PRE_POS]   = pre_en;
         rdata[DONE_POS]  = done;
      end else if (data_hit) begin
         rdata[RD_BITS-1:0] = cap;
      end
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int              ADDR_W       = 12,
   parameter int              DIV_W        = 7,
   parameter bit              HAS_PREAMBLE = 1'b1,
   parameter logic [ADDR_W-1:0] CTRL_OFS   = ADDR_W'(12'h128),
   parameter logic [ADDR_W-1:0] DATA_OFS   = ADDR_W'(12'h12C)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   if (DIV_W < 1 || DIV_W > 7) begin : g_bad_div
      $error("mdio_master: divisor width must be 1..7");
   end
   if (CTRL_OFS == DATA_OFS) begin : g_bad_ofs
      $error("mdio_master: register offsets collide");
   end

   logic [DIV_W-1:0]   div;
   logic               pre_en;
   logic               enabled;
   logic               done_flag;
   logic               start;
   logic               busy;
   logic               rise_tick;
   logic               fall_tick;
   logic               done_pulse;
   logic [RD_BITS-1:0] cap;

   mdio_regs #(
      .ADDR_W      (ADDR_W),
      .DIV_W       (DIV_W),
      .HAS_PREAMBLE(HAS_PREAMBLE),
      .CTRL_OFS    (CTRL_OFS),
      .DATA_OFS    (DATA_OFS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .busy      (busy),
      .done_pulse(done_pulse),
      .cap       (cap),
      .div       (div),
      .pre_en    (pre_en),
      .enabled   (enabled),
      .done      (done_flag),
      .start     (start),
      .rdata     (reg_rdata)
   );

   mdio_clkgen #(
      .DIV_W(DIV_W)
   ) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .div      (div),
      .mdc      (mdc),
      .rise_tick(rise_tick),
      .fall_tick(fall_tick)
   );

   mdio_shifter u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cmd       (reg_wdata),
      .pre_en    (pre_en),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_i    (mdio_i),
      .busy      (busy),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .done_pulse(done_pulse),
      .cap       (cap)
   );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int              ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(12'h12C)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              mdc,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic              busy,
   input logic              enabled,
   input logic              done_flag
);
   // R3: data line held while the management clock stays high
   p_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R3: clock parked low when no transaction runs
   p_mdc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R5: line released while idle
   p_oe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);

   // R7: flag low during a transaction, high once it ends
   p_done_low_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done_flag);

   p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_flag);

   // R9: disabled controller ignores a frame write
   p_no_start_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !enabled && reg_wr && reg_addr == DATA_OFS) |=> !busy);
endmodule

bind mdio_master mdio_master_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_OFS(DATA_OFS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .mdc      (mdc),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe),
   .busy     (busy),
   .enabled  (enabled),
   .done_flag(done_flag)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
   localparam logic [11:0] CTRL = 12'h128;
   localparam logic [11:0] DATA = 12'h12C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [63:0] obs = '0;
   logic [63:0] oe_obs = '0;
   int rise_cnt = 0;
   int fall_cnt = 0;
   int cyc = 0;
   int last_rise = 0;
   int per = 0;
   bit phy_en = 1'b0;
   int phy_base = 0;
   logic [15:0] phy_pat = '0;

   mdio_master dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always #5 clk = ~clk;
   always @(negedge clk) cyc++;

   always @(posedge mdc) begin
      obs    = {obs[62:0], mdio_o};
      oe_obs = {oe_obs[62:0], mdio_oe};
      rise_cnt++;
      per = cyc - last_rise;
      last_rise = cyc;
   end

   // device model: drives the next data bit after each falling edge
   always @(negedge mdc) begin
      int nxt;
      fall_cnt++;
      nxt = fall_cnt - phy_base;
      if (phy_en && nxt >= 16 && nxt <= 31) mdio_i = phy_pat[31 - nxt];
      else mdio_i = 1'b1;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic clr_obs();
      obs = '0; oe_obs = '0; rise_cnt = 0; fall_cnt = 0; phy_en = 1'b0;
   endtask

   task automatic wait_done();
      logic [31:0] v;
      for (int i = 0; i < 4000; i++) begin
         rd(CTRL, v);
         if (v[8]) break;
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 mdc reset", 64'(mdc), 64'd0);
      chk("R5 oe reset", 64'(mdio_oe), 64'd0);
      rd(CTRL, v); chk("R1 ctrl reset", 64'(v), 64'd0);
      rd(DATA, v); chk("R1 data reset", 64'(v), 64'd0);
      rd(12'h130, v); chk("R1 unmapped offset", 64'(v), 64'd0);
   endtask

   task automatic t_write_pre();
      logic [31:0] v;
      logic [31:0] cmd = 32'h5000_0000 | (32'h0B << 23) | (32'h04 << 18) | (32'h1 << 17) | 32'hBEEF;
      clr_obs();
      wr(CTRL, 32'h82);
      rd(CTRL, v); chk("R1 ctrl readback", 64'(v[7:0]), 64'h82);
      wr(DATA, cmd);
      wait (rise_cnt == 64);
      rd(CTRL, v); chk("R7 flag clear at last rise", 64'(v[8]), 64'd0);
      @(negedge mdc);
      rd(CTRL, v); chk("R7 flag set after final fall", 64'(v[8]), 64'd1);
      chk("R4 preamble ones", 64'(obs[63:32]), 64'hFFFF_FFFF);
      chk("R2 frame verbatim", 64'(obs[31:0]), 64'(cmd));
      chk("R5 oe on write frame", oe_obs, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R3 period div2", 64'(per), 64'd6);
      repeat (20) @(negedge clk);
      chk("R4 bit count with preamble", 64'(rise_cnt), 64'd64);
   endtask

   task automatic t_read();
      logic [31:0] v;
      logic [31:0] cmd = 32'h6000_0000 | (32'h03 << 23) | (32'h02 << 18) | (32'h1 << 17);
      clr_obs();
      phy_en = 1'b1; phy_base = 32; phy_pat = 16'hA5C3;
      wr(DATA, cmd);
      wait_done();
      rd(DATA, v); chk("R6 read data", 64'(v), 64'h0000_A5C3);
      chk("R5 oe release from bit16", oe_obs, 64'hFFFF_FFFF_FFFE_0000);
      chk("R2 read header verbatim", 64'(obs[31:17]), 64'(cmd[31:17]));
   endtask

   task automatic t_no_pre_div5();
      logic [31:0] v;
      logic [31:0] cmd = 32'h5000_0000 | (32'h11 << 23) | (32'h07 << 18) | (32'h1 << 17) | 32'h1234;
      clr_obs();
      wr(CTRL, 32'h05);
      wr(DATA, cmd);
      rd(CTRL, v); chk("R7 flag cleared at start", 64'(v[8]), 64'd0);
      wait_done();
      repeat (20) @(negedge clk);
      chk("R4 no preamble count", 64'(rise_cnt), 64'd32);
      chk("R4 no preamble frame", 64'(obs[31:0]), 64'(cmd));
      chk("R3 period div5", 64'(per), 64'd12);
   endtask

   task automatic t_devsel();
      logic [31:0] cmd = 32'h5000_0000 | (32'h1F << 18) | (32'h1 << 17) | (32'h0D << 4);
      clr_obs();
      wr(CTRL, 32'h80);
      wr(DATA, cmd);
      wait_done();
      chk("R2 device select frame", 64'(obs[31:0]), 64'(cmd));
      chk("R3 period div0", 64'(per), 64'd2);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] a = 32'h5000_0000 | (32'h02 << 23) | (32'h1 << 17) | 32'hC0DE;
      logic [31:0] b = 32'h6FFF_FFFF;
      clr_obs();
      wr(CTRL, 32'h02);
      wr(DATA, a);
      repeat (40) @(negedge clk);
      wr(DATA, b);
      wait_done();
      repeat (20) @(negedge clk);
      chk("R8 frame unchanged", 64'(obs[31:0]), 64'(a));
      chk("R8 bit count unchanged", 64'(rise_cnt), 64'd32);
   endtask

   task automatic t_disabled();
      logic [31:0] v;
      clr_obs();
      wr(CTRL, 32'h0);
      wr(DATA, 32'h5000_0000);
      repeat (100) @(negedge clk);
      chk("R9 no clock when disabled", 64'(rise_cnt), 64'd0);
      chk("R9 line released", 64'(mdio_oe), 64'd0);
      rd(CTRL, v); chk("R9 flag kept", 64'(v[8]), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_pre();
      t_read();
      t_no_pre_div5();
      t_devsel();
      t_busy_ignore();
      t_disabled();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog act=running exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule